// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Controller

This block watches 32 already-synchronized GPIO inputs and turns chosen pin activity into latched interrupt status. Each pin has its own 4-bit sense code that selects rising edge, falling edge, both edges, high level or low level. Each pin also has a detection-enable bit that gates new events, and a mask bit that decides whether its latched status reaches an interrupt line. Pins 0 to 15 feed the low request output and pins 16 to 31 feed the high request output.

Software reaches the block through a simple 32-bit register bus with single-cycle write strobes and a combinational read port. The mask is never written directly. A write-one strobe unmasks pins and a second write-one strobe masks them. Reading the masking strobe's address returns the current mask. Pending status is cleared by writing ones to a clear address. The sense codes live eight per word in a block of four words starting at 0x40.

Top module: `gpio_irq_sense_top`

## Requirements
- R1: After reset every pin is masked (a read of 0x1C returns 0xFFFFFFFF). Detection-enable (0x14), raw status (0x20), masked status (0x24) and all sense words (0x40..0x4C) read 0, and both request outputs are low.
- R2: Offset 0x14 is a read/write detection-enable vector, with bit n for pin n. A pin whose enable bit is 0 never sets its status bit, whatever its sense code and activity.
- R3: Writing 1 to bit n at 0x18 clears pin n's mask bit (unmask), and writing 1 to bit n at 0x1C sets it (mask). Zero bits in those writes leave the mask unchanged. A read of 0x1C returns the mask, where 1 means masked.
- R4: The sense words at 0x40, 0x44, 0x48 and 0x4C are read/write. Pin p uses word p/8, bits [4*(p%8)+3 : 4*(p%8)].
- R5: Code 8 latches on a rising edge, code 9 on a falling edge and code 12 on either edge. An edge is a pin value at a clock edge that differs from its value at the previous clock edge, and the status bit reads as 1 after that clock edge.
- R6: Code 10 (high) and code 11 (low) set status on every clock edge at which the level holds. A clear takes lasting effect only once the level is gone.
- R7: Any sense code other than 8 to 12 (including 0, 7 and 13) never sets status.
- R8: Writing 1 to bit n at 0x28 clears pin n's pending status bit, and zero bits leave status unchanged.
- R9: If an event is detected for pin n in the same cycle that a clear of bit n is written, the bit stays pending.
- R10: A read of 0x20 returns the raw latched status, and a read of 0x24 returns raw status AND NOT mask.
- R11: The low request output is the OR of masked status bits 0 to 15, and the high request output is the OR of masked status bits 16 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one word per cycle |
| busRdEn | input | 1 | Read enable; read data is 0 when low |
| busAddr | input | 8 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data |
| pinIn | input | 32 | Synchronized GPIO pin levels |
| irqLow | output | 1 | Request for pins 0 to 15 |
| irqHigh | output | 1 | Request for pins 16 to 31 |

## Verification
The hardest situations to reach from the ports are those where a software clear and pin activity meet in the same clock. One case is a clear written in the exact cycle that a new edge arrives. The other is a clear issued while a level condition still holds. The bench reaches the first by changing the pin on the same falling clock edge that presents the clear write. Both then meet at one rising edge. It reaches the second by holding a pin at its active level across the clear write, then releasing the level and clearing again to show that the bit finally drops.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  parameter int unsigned GI_PINS     = 32;
  parameter int unsigned GI_PER_WORD = 8;

  typedef enum logic [3:0] {
    SENSE_OFF  = 4'd0,
    SENSE_RISE = 4'd8,
    SENSE_FALL = 4'd9,
    SENSE_HIGH = 4'd10,
    SENSE_LOW  = 4'd11,
    SENSE_BOTH = 4'd12
  } sense_code_e;

  // Register offsets (byte addresses)
  localparam logic [7:0] OFS_DETECT_EN = 8'h14;
  localparam logic [7:0] OFS_UNMASK    = 8'h18;
  localparam logic [7:0] OFS_MASK      = 8'h1C;
  localparam logic [7:0] OFS_RAW       = 8'h20;
  localparam logic [7:0] OFS_PENDING   = 8'h24;
  localparam logic [7:0] OFS_CLEAR     = 8'h28;
  localparam logic [7:0] OFS_SENSE     = 8'h40;

  // Strobes from the register control to the datapath
  typedef struct packed {
    logic               clrValid;
    logic [GI_PINS-1:0] clrBits;
  } clr_strobe_t;

  function automatic logic senseHit(input logic [3:0] code,
                                    input logic       nowVal,
                                    input logic       prevVal);
    logic hit;
    case (code)
      SENSE_RISE: hit = nowVal & ~prevVal;
      SENSE_FALL: hit = ~nowVal & prevVal;
      SENSE_HIGH: hit = nowVal;
      SENSE_LOW:  hit = ~nowVal;
      SENSE_BOTH: hit = nowVal ^ prevVal;
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = GI_PINS,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         busWrEn,
  input  logic                         busRdEn,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWrData,
  output logic [DATA_W-1:0]            busRdData,
  input  logic [NUM_PINS-1:0]          rawStatus,
  input  logic [NUM_PINS-1:0]          maskedStatus,
  output logic [NUM_PINS-1:0]          enableVec,
  output logic [NUM_PINS-1:0]          maskVec,
  output logic [NUM_PINS-1:0][3:0]     senseCode,
  output clr_strobe_t                  clrStrobe
);

  localparam int unsigned NUM_WORDS = NUM_PINS / GI_PER_WORD;

  function automatic logic [ADDR_W-1:0] senseAddr(input int unsigned k);
    return ADDR_W'(int'(OFS_SENSE) + 4 * k);
  endfunction

  logic wrEnable, wrUnmask, wrMask, wrClear;

  always_comb begin
    wrEnable = busWrEn && (busAddr == ADDR_W'(OFS_DETECT_EN));
    wrUnmask = busWrEn && (busAddr == ADDR_W'(OFS_UNMASK));
    wrMask   = busWrEn && (busAddr == ADDR_W'(OFS_MASK));
    wrClear  = busWrEn && (busAddr == ADDR_W'(OFS_CLEAR));
  end

  always_comb begin
    clrStrobe.clrValid = wrClear;
    clrStrobe.clrBits  = busWrData[NUM_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enableVec <= '0;
    end else if (wrEnable) begin
      enableVec <= busWrData[NUM_PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskVec <= '1;
    end else if (wrUnmask) begin
      maskVec <= maskVec & ~busWrData[NUM_PINS-1:0];
    end else if (wrMask) begin
      maskVec <= maskVec | busWrData[NUM_PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      senseCode <= '0;
    end else if (busWrEn) begin
      for (int unsigned k = 0; k < NUM_WORDS; k++) begin
        if (busAddr == senseAddr(k)) begin
          senseCode[k*GI_PER_WORD +: GI_PER_WORD] <= busWrData;
        end
      end
    end
  end

  logic [NUM_WORDS-1:0][DATA_W-1:0] senseWords;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign senseWords[w] = senseCode[w*GI_PER_WORD +: GI_PER_WORD];
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      unique case (busAddr)
        ADDR_W'(OFS_DETECT_EN): busRdData = DATA_W'(enableVec);
        ADDR_W'(OFS_MASK):      busRdData = DATA_W'(maskVec);
        ADDR_W'(OFS_RAW):       busRdData = DATA_W'(rawStatus);
        ADDR_W'(OFS_PENDING):   busRdData = DATA_W'(maskedStatus);
        default: begin
          for (int unsigned k = 0; k < NUM_WORDS; k++) begin
            if (busAddr == senseAddr(k)) busRdData = senseWords[k];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = GI_PINS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_PINS-1:0]      pinIn,
  input  logic [NUM_PINS-1:0]      enableVec,
  input  logic [NUM_PINS-1:0]      maskVec,
  input  logic [NUM_PINS-1:0][3:0] senseCode,
  input  clr_strobe_t              clrStrobe,
  output logic [NUM_PINS-1:0]      rawStatus,
  output logic [NUM_PINS-1:0]      maskedStatus,
  output logic                     irqLow,
  output logic                     irqHigh
);

  localparam int unsigned HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] prevPin;
  logic [NUM_PINS-1:0] hitVec;
  logic [NUM_PINS-1:0] eventVec;
  logic [NUM_PINS-1:0] clearVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevPin <= '0;
    else        prevPin <= pinIn;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign hitVec[i] = senseHit(senseCode[i], pinIn[i], prevPin[i]);
  end

  always_comb begin
    eventVec = hitVec & enableVec;
    clearVec = clrStrobe.clrValid ? clrStrobe.clrBits : '0;
  end

  // A new event overrides a simultaneous clear of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rawStatus <= '0;
    else        rawStatus <= (rawStatus & ~clearVec) | eventVec;
  end

  always_comb begin
    maskedStatus = rawStatus & ~maskVec;
    irqLow       = |maskedStatus[HALF-1:0];
    irqHigh      = |maskedStatus[NUM_PINS-1:HALF];
  end

endmodule

// File: rtl/gpio_irq_sense_top.sv
module gpio_irq_sense_top
  import gpio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [GI_PINS-1:0] pinIn,
  output logic              irqLow,
  output logic              irqHigh
);

  localparam int unsigned NUM_PINS = GI_PINS;

  logic [NUM_PINS-1:0]      enableVec;
  logic [NUM_PINS-1:0]      maskVec;
  logic [NUM_PINS-1:0][3:0] senseCode;
  logic [NUM_PINS-1:0]      rawStatus;
  logic [NUM_PINS-1:0]      maskedStatus;
  clr_strobe_t              clrStrobe;

  gpio_irq_regs #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busWrEn     (busWrEn),
    .busRdEn     (busRdEn),
    .busAddr     (busAddr),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .rawStatus   (rawStatus),
    .maskedStatus(maskedStatus),
    .enableVec   (enableVec),
    .maskVec     (maskVec),
    .senseCode   (senseCode),
    .clrStrobe   (clrStrobe)
  );

  gpio_irq_detect #(
    .NUM_PINS(NUM_PINS)
  ) detect_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pinIn       (pinIn),
    .enableVec   (enableVec),
    .maskVec     (maskVec),
    .senseCode   (senseCode),
    .clrStrobe   (clrStrobe),
    .rawStatus   (rawStatus),
    .maskedStatus(maskedStatus),
    .irqLow      (irqLow),
    .irqHigh     (irqHigh)
  );

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk
  import gpio_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               busWrEn,
  input logic [GI_PINS-1:0] enableVec,
  input logic [GI_PINS-1:0] maskVec,
  input logic [GI_PINS-1:0] rawStatus,
  input clr_strobe_t        clrStrobe,
  input logic               irqLow,
  input logic               irqHigh
);

  localparam int unsigned HALF = GI_PINS / 2;

  logic [GI_PINS-1:0] clrSeen;
  assign clrSeen = clrStrobe.clrValid ? clrStrobe.clrBits : '0;

  // R2
  disabled_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rawStatus & ~$past(rawStatus) & ~$past(enableVec)) == '0);

  // R8
  fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rawStatus) & ~rawStatus & ~$past(clrSeen)) == '0);

  // R3
  mask_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busWrEn) |-> $stable(maskVec));

  // R11
  high_req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqHigh |-> ((rawStatus[GI_PINS-1:HALF] & ~maskVec[GI_PINS-1:HALF]) != '0));

  // R11
  low_req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqLow |-> ((rawStatus[HALF-1:0] & ~maskVec[HALF-1:0]) != '0));

  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rawStatus == '0) |-> (!irqLow && !irqHigh));

endmodule

bind gpio_irq_sense_top gpio_irq_sense_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busWrEn  (busWrEn),
  .enableVec(enableVec),
  .maskVec  (maskVec),
  .rawStatus(rawStatus),
  .clrStrobe(clrStrobe),
  .irqLow   (irqLow),
  .irqHigh  (irqHigh)
);

// File: tb/gpio_irq_sense_top_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_sense_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] pinIn = '0;
  logic        irqLow, irqHigh;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_sense_top dut_i (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .pinIn(pinIn), .irqLow(irqLow), .irqHigh(irqHigh)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; pinIn = '0; busWrEn = 1'b0; busRdEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = addr;
    #1 data = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic setPins(input logic [31:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic testReset();
    logic [31:0] d;
    doReset();
    rd(8'h1C, d); chk("R1 mask after reset", d, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R1 enable after reset", d, 32'h0);
    rd(8'h20, d); chk("R1 raw after reset", d, 32'h0);
    rd(8'h24, d); chk("R1 masked after reset", d, 32'h0);
    rd(8'h40, d); chk("R1 sense0 after reset", d, 32'h0);
    rd(8'h4C, d); chk("R1 sense3 after reset", d, 32'h0);
    chk("R1 request lines after reset", {30'd0, irqHigh, irqLow}, 32'h0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    doReset();
    wr(8'h14, 32'hA5A5_0F0F);
    rd(8'h14, d); chk("R2 enable readback", d, 32'hA5A5_0F0F);
    wr(8'h18, 32'h0000_00FF);
    rd(8'h1C, d); chk("R3 unmask strobe", d, 32'hFFFF_FF00);
    wr(8'h1C, 32'h0000_000F);
    rd(8'h1C, d); chk("R3 mask strobe", d, 32'hFFFF_FF0F);
    wr(8'h44, 32'h1234_5678);
    wr(8'h4C, 32'hCBA9_8CBA);
    rd(8'h44, d); chk("R4 sense word 1 readback", d, 32'h1234_5678);
    rd(8'h4C, d); chk("R4 sense word 3 readback", d, 32'hCBA9_8CBA);
    rd(8'h40, d); chk("R4 sense word 0 untouched", d, 32'h0);
  endtask

  task automatic testEdges();
    logic [31:0] d;
    doReset();
    wr(8'h40, 32'h0000_8000);   // pin 3 rise
    wr(8'h44, 32'h0000_0090);   // pin 9 fall
    wr(8'h48, 32'h000C_0000);   // pin 20 both
    wr(8'h14, 32'h0010_0208);
    setPins(32'h0010_0208);
    rd(8'h20, d); chk("R5 rise and both latch on rising", d, 32'h0010_0008);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R8 clear all", d, 32'h0);
    setPins(32'h0);
    rd(8'h20, d); chk("R5 fall and both latch on falling", d, 32'h0010_0200);
  endtask

  task automatic testLevels();
    logic [31:0] d;
    doReset();
    wr(8'h40, 32'h0BA0_0000);   // pin 5 high, pin 6 low
    wr(8'h14, 32'h0000_0060);
    rd(8'h20, d); chk("R6 low level latches", d, 32'h0000_0040);
    setPins(32'h0000_0020);
    rd(8'h20, d); chk("R6 high level latches", d, 32'h0000_0060);
    wr(8'h28, 32'h0000_0060);
    rd(8'h20, d); chk("R6 clear ineffective while level holds", d, 32'h0000_0060);
    setPins(32'h0000_0040);
    wr(8'h28, 32'h0000_0060);
    rd(8'h20, d); chk("R6 clear after level gone", d, 32'h0);
  endtask

  task automatic testIgnored();
    logic [31:0] d;
    doReset();
    wr(8'h40, 32'hC000_07D0);   // pin 7 both, pin 2 code 7, pin 1 code 13, pin 0 code 0
    wr(8'h14, 32'h0000_0007);   // pin 7 not enabled
    setPins(32'h0000_0087);
    setPins(32'h0000_0000);
    setPins(32'h0000_0080);
    rd(8'h20, d); chk("R2 disabled pin never latches", d & 32'h80, 32'h0);
    chk("R7 invalid codes never latch", d & 32'h7, 32'h0);
  endtask

  task automatic testCollision();
    logic [31:0] d;
    doReset();
    wr(8'h40, 32'h0000_0800);   // pin 2 rise
    wr(8'h14, 32'h0000_0004);
    setPins(32'h0000_0004);
    rd(8'h20, d); chk("R5 pin 2 rise", d, 32'h0000_0004);
    wr(8'h28, 32'h0000_0001);
    rd(8'h20, d); chk("R8 clear of other bit leaves status", d, 32'h0000_0004);
    wr(8'h28, 32'h0000_0004);
    rd(8'h20, d); chk("R8 clear single bit", d, 32'h0);
    setPins(32'h0);
    @(negedge clk);
    pinIn = 32'h0000_0004;
    busWrEn = 1'b1; busAddr = 8'h28; busWrData = 32'h0000_0004;
    @(negedge clk);
    busWrEn = 1'b0;
    rd(8'h20, d); chk("R9 edge wins over same-cycle clear", d, 32'h0000_0004);
  endtask

  task automatic testMaskIrq();
    logic [31:0] d;
    doReset();
    wr(8'h40, 32'h0008_0000);   // pin 4 rise
    wr(8'h4C, 32'h0000_0080);   // pin 25 rise
    wr(8'h14, 32'h0200_0010);
    setPins(32'h0200_0010);
    rd(8'h20, d); chk("R10 raw ignores mask", d, 32'h0200_0010);
    rd(8'h24, d); chk("R10 masked status all masked", d, 32'h0);
    chk("R11 no request while masked", {30'd0, irqHigh, irqLow}, 32'h0);
    wr(8'h18, 32'h0000_0010);
    rd(8'h24, d); chk("R10 masked after unmask pin 4", d, 32'h0000_0010);
    chk("R11 low request only", {30'd0, irqHigh, irqLow}, 32'h1);
    wr(8'h18, 32'h0200_0000);
    chk("R11 both requests", {30'd0, irqHigh, irqLow}, 32'h3);
    wr(8'h1C, 32'h0000_0010);
    rd(8'h24, d); chk("R3 remask pin 4", d, 32'h0200_0000);
    chk("R11 high request only", {30'd0, irqHigh, irqLow}, 32'h2);
    wr(8'h28, 32'h0200_0000);
    chk("R11 requests drop after clear", {30'd0, irqHigh, irqLow}, 32'h0);
  endtask

  initial begin
    testReset();
    testRegs();
    testEdges();
    testLevels();
    testIgnored();
    testCollision();
    testMaskIrq();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule